// File: doc/BRIEF.md
# Key-Unlocked System Control Register File

This block is a bank of 32-bit system control registers behind a simple single-cycle bus port. Each request carries a valid strobe, a write flag, a byte address and write data. Only word-aligned accesses are served. Most of the lower registers are protected. They accept writes only after software has written a fixed magic value to the key word at address 0x00. Any later write to the key word checks the value again, so a wrong value locks the bank again.

At reset the block loads some of its words from input pins: two hardware strap words, a revision word and the initial state of the key word. All other words take fixed constants. The first strap word has special write rules. A write to it sets bits (OR). A write to the revision address leaves the revision alone and clears the strap bits that are set in the data. A random-data word gives a new value on every read. The value comes from an internal 32-bit LFSR. Some words are read-only. Writes that are refused raise a one-cycle error pulse.

Top module: `sysctl_keyed_regs`

## Requirements
- R1: A write to address 0x00 stores 1 when the data equals the parameter KEY (default 0x1688A8A8) and stores 0 otherwise. The write is never refused, and the word reads back as 0 or 1.
- R2: While word 0x00 reads 0, writes to aligned addresses 0x04 through 0x100 are discarded and raise the error pulse. Addresses from 0x104 up stay writable.
- R3: An accepted write to the strap word at 0x70 ORs the data into the stored value.
- R4: An accepted write to 0x7C leaves the revision word unchanged and clears every bit of the 0x70 strap word that is 1 in the data.
- R5: Reads of 0x78 return the LFSR state. The first read after reset returns SEED (default 0xACE1ACE1). Each read of 0x78 advances the state s to {s[30:0], s[31]^s[21]^s[1]^s[0]}. The value at 0x74 has no effect on this.
- R6: Writes to 0x14, 0x50 through 0x6C, 0x78, 0xE0, 0xE4, 0x150 and 0x154 change nothing and raise the error pulse.
- R7: An access whose word index (address/4) is NREGS (default 106) or more reads 0. A write to such an address changes nothing and raises the error pulse.
- R8: Reset loads 0x00 from lock_in, 0x70 from strap1_in, 0xD0 from strap2_in and 0x7C from rev_in. Fixed constants include 0x04=0xFFCFFEDC, 0x08=0xF3F40000, 0xE0=0x000000FF, 0x150=0x1234ABCD and 0x104=0x80000000. Unlisted words reset to 0.
- R9: An address with bits [1:0] not zero is refused: a write changes nothing and pulses the error flag, and a read returns 0.
- R10: bus_rvalid and bus_rdata appear in the cycle after a read is accepted. bus_err is high in the cycle after a refused write. Both flags are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | One-cycle pulse for a refused write |
| strap1_in | input | 32 | Reset value of the strap word at 0x70 |
| strap2_in | input | 32 | Reset value of the strap word at 0xD0 |
| rev_in | input | 32 | Reset value of the revision word |
| lock_in | input | 32 | Reset value of the key word |

## Verification
A wrong lock state shows at the ports one cycle after the next protected write. That write either pulses bus_err when it should not, or it fails to pulse it. A read-back of the target word then confirms whether the data landed. A corrupted strap word or a wrong LFSR step shows in the first read of 0x70 or 0x78 that follows, because each read is compared against values worked out from the set/clear rules and the shift recurrence. Errors in the address decode show as a wrong error pulse, or as nonzero data from an out-of-range or misaligned read, in the cycle after the request.

// File: rtl/scu_pkg.sv
package scu_pkg;

  typedef enum logic [2:0] {
    WR_NONE,
    WR_KEY,
    WR_PLAIN,
    WR_OR,
    WR_CLR
  } wr_kind_e;

  // Word indices whose position the behaviour depends on
  localparam int unsigned W_KEY     = 0;
  localparam int unsigned W_FREQ    = 5;
  localparam int unsigned W_SCR_LO  = 20;
  localparam int unsigned W_SCR_HI  = 27;
  localparam int unsigned W_STRAP   = 28;
  localparam int unsigned W_RNG     = 30;
  localparam int unsigned W_REV     = 31;
  localparam int unsigned W_STRAP2  = 52;
  localparam int unsigned W_FC0     = 56;
  localparam int unsigned W_FC1     = 57;
  localparam int unsigned W_OPEN_LO = 65;
  localparam int unsigned W_ID0     = 84;
  localparam int unsigned W_ID1     = 85;

  function automatic logic [31:0] fixed_init(input int unsigned w);
    case (w)
      1:       return 32'hFFCF_FEDC;
      2:       return 32'hF3F4_0000;
      3:       return 32'h19FC_3E8B;
      15:      return 32'h0000_0001;
      19:      return 32'h0000_0023;
      29:      return 32'h0000_000E;
      56, 57:  return 32'h0000_00FF;
      65:      return 32'h8000_0000;
      84:      return 32'h1234_ABCD;
      85:      return 32'h8888_4444;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic is_read_only(input int unsigned w);
    return (w == W_FREQ) || (w >= W_SCR_LO && w <= W_SCR_HI) ||
           (w == W_RNG) || (w == W_FC0) || (w == W_FC1) ||
           (w == W_ID0) || (w == W_ID1);
  endfunction

endpackage

// File: rtl/scu_rng.sv
module scu_rng #(
  parameter int unsigned     WIDTH = 32,
  parameter logic [WIDTH-1:0] SEED = 32'hACE1_ACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [WIDTH-1:0] value
);
  logic fb;

  assign fb = value[31] ^ value[21] ^ value[1] ^ value[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= SEED;
    end else if (step) begin
      value <= {value[WIDTH-2:0], fb};
    end
  end
endmodule

// File: rtl/scu_decode.sv
module scu_decode
  import scu_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NREGS  = 106,
  localparam int unsigned SEL_W = $clog2(NREGS)
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock_open,
  output logic [SEL_W-1:0]  sel,
  output logic              rd_ok,
  output logic              rd_rng,
  output wr_kind_e          wr_kind,
  output logic              wr_reject
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             in_range;
  int unsigned      w;
  logic             guarded;

  assign idx      = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_range = (int'(idx) < int'(NREGS));
  assign w        = in_range ? int'(idx) : 0;
  assign sel      = SEL_W'(w);
  assign guarded  = (w > W_KEY) && (w < W_OPEN_LO);

  always_comb begin
    rd_ok     = valid && !write && aligned && in_range;
    rd_rng    = rd_ok && (w == W_RNG);
    wr_kind   = WR_NONE;
    wr_reject = 1'b0;
    if (valid && write) begin
      if (!aligned || !in_range) begin
        wr_reject = 1'b1;
      end else if (w == W_KEY) begin
        wr_kind = WR_KEY;
      end else if (guarded && !lock_open) begin
        wr_reject = 1'b1;
      end else if (w == W_STRAP) begin
        wr_kind = WR_OR;
      end else if (w == W_REV) begin
        wr_kind = WR_CLR;
      end else if (is_read_only(w)) begin
        wr_reject = 1'b1;
      end else begin
        wr_kind = WR_PLAIN;
      end
    end
  end
endmodule

// File: rtl/scu_store.sv
module scu_store
  import scu_pkg::*;
#(
  parameter int unsigned NREGS = 106,
  parameter logic [31:0] KEY   = 32'h1688_A8A8,
  localparam int unsigned SEL_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      strap1_in,
  input  logic [31:0]      strap2_in,
  input  logic [31:0]      rev_in,
  input  logic [31:0]      lock_in,
  input  wr_kind_e         wr_kind,
  input  logic [SEL_W-1:0] sel,
  input  logic [31:0]      wdata,
  output logic [31:0]      rd_word,
  output logic             lock_open
);
  logic [31:0] words [NREGS];

  assign rd_word   = (int'(sel) < int'(NREGS)) ? words[sel] : 32'h0;
  assign lock_open = (words[W_KEY] != 32'h0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NREGS); i++) begin
        words[i] <= fixed_init(i);
      end
      words[W_KEY]    <= lock_in;
      words[W_STRAP]  <= strap1_in;
      words[W_STRAP2] <= strap2_in;
      words[W_REV]    <= rev_in;
    end else begin
      case (wr_kind)
        WR_KEY:   words[W_KEY]   <= (wdata == KEY) ? 32'd1 : 32'd0;
        WR_PLAIN: words[sel]     <= wdata;
        WR_OR:    words[W_STRAP] <= words[W_STRAP] | wdata;
        WR_CLR:   words[W_STRAP] <= words[W_STRAP] & ~wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_keyed_regs.sv
module sysctl_keyed_regs
  import scu_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NREGS  = 106,
  parameter logic [31:0] KEY    = 32'h1688_A8A8,
  parameter logic [31:0] SEED   = 32'hACE1_ACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  input  logic [31:0]       strap1_in,
  input  logic [31:0]       strap2_in,
  input  logic [31:0]       rev_in,
  input  logic [31:0]       lock_in
);
  localparam int unsigned SEL_W = $clog2(NREGS);

  logic [SEL_W-1:0] sel;
  logic             rd_ok;
  logic             rd_rng;
  wr_kind_e         wr_kind;
  logic             wr_reject;
  logic             lock_open;
  logic [31:0]      rd_word;
  logic [31:0]      rng_value;

  scu_decode #(.ADDR_W(ADDR_W), .NREGS(NREGS)) u_decode (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr),
    .lock_open(lock_open), .sel(sel), .rd_ok(rd_ok), .rd_rng(rd_rng),
    .wr_kind(wr_kind), .wr_reject(wr_reject)
  );

  scu_store #(.NREGS(NREGS), .KEY(KEY)) u_store (
    .clk(clk), .rst(rst), .strap1_in(strap1_in), .strap2_in(strap2_in),
    .rev_in(rev_in), .lock_in(lock_in), .wr_kind(wr_kind), .sel(sel),
    .wdata(bus_wdata), .rd_word(rd_word), .lock_open(lock_open)
  );

  scu_rng #(.WIDTH(32), .SEED(SEED)) u_rng (
    .clk(clk), .rst(rst), .step(rd_rng), .value(rng_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= 32'h0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      bus_err    <= wr_reject;
      if (rd_ok) begin
        bus_rdata <= rd_rng ? rng_value : rd_word;
      end else begin
        bus_rdata <= 32'h0;
      end
    end
  end
endmodule

// File: rtl/scu_checker.sv
module scu_checker #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NREGS  = 106
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              bus_err,
  input logic              lock_open
);
  localparam logic [ADDR_W-1:0] A_GUARD_LO = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_GUARD_HI = ADDR_W'(256);
  localparam logic [ADDR_W-1:0] A_ID0      = ADDR_W'(336);
  localparam logic [ADDR_W-1:0] A_LIMIT    = ADDR_W'(NREGS * 4);

  logic wr_req;
  logic rd_req;
  assign wr_req = bus_valid && bus_write;
  assign rd_req = bus_valid && !bus_write;

  a_r1_key_write_accepted: assert property (@(posedge clk) disable iff (rst)
    wr_req && bus_addr == '0 |=> !bus_err);

  a_r2_locked_write_refused: assert property (@(posedge clk) disable iff (rst)
    wr_req && !lock_open && bus_addr >= A_GUARD_LO && bus_addr <= A_GUARD_HI
    |=> bus_err);

  a_r6_chip_id_read_only: assert property (@(posedge clk) disable iff (rst)
    wr_req && bus_addr == A_ID0 |=> bus_err);

  a_r7_out_of_range_reads_zero: assert property (@(posedge clk) disable iff (rst)
    rd_req && bus_addr >= A_LIMIT |=> bus_rdata == 32'h0);

  a_r9_misaligned_write_refused: assert property (@(posedge clk) disable iff (rst)
    wr_req && bus_addr[1:0] != 2'b00 |=> bus_err);

  a_r10_read_acknowledged: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid && !bus_err);

  a_r10_idle_is_quiet: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !bus_rvalid && !bus_err);
endmodule

bind sysctl_keyed_regs scu_checker #(.ADDR_W(ADDR_W), .NREGS(NREGS)) u_checker (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .bus_err(bus_err), .lock_open(lock_open)
);

// File: tb/tb_sysctl_keyed_regs.sv
module tb_sysctl_keyed_regs;
  localparam logic [31:0] KEY  = 32'h1688_A8A8;
  localparam logic [31:0] SEED = 32'hACE1_ACE1;
  localparam logic [31:0] S1   = 32'h00F0_0001;
  localparam logic [31:0] S2   = 32'h5A5A_0002;
  localparam logic [31:0] REV  = 32'h0402_0303;

  logic        clk = 0;
  logic        rst = 1;
  logic        bus_valid = 0;
  logic        bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        bus_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        rd;
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  sysctl_keyed_regs #(.ADDR_W(12), .NREGS(106), .KEY(KEY), .SEED(SEED)) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .strap1_in(S1),
    .strap2_in(S2), .rev_in(REV), .lock_in(32'h0)
  );

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic issue(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [31:0] exp_d, input logic exp_e, input string tag);
    exp_t it;
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = d;
    it.rd = !wr; it.data = exp_d; it.err = exp_e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic e, input string tag);
    issue(1'b1, a, d, 32'h0, e, tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp_d, input string tag);
    issue(1'b0, a, 32'h0, exp_d, 1'b0, tag);
  endtask

  // monitor: compares one expected item per issued access, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (bus_rvalid !== it.rd || bus_err !== it.err ||
          (it.rd && bus_rdata !== it.data)) begin
        errors++;
        $display("FAIL %s: rvalid=%0b err=%0b rdata=%08h, expected rvalid=%0b err=%0b rdata=%08h",
                 it.tag, bus_rvalid, bus_err, bus_rdata, it.rd, it.err, it.data);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    repeat (4) @(negedge clk);
    rst = 0;

    // R8 reset state
    rd(12'h004, 32'hFFCF_FEDC, "R8 reset ctrl");
    rd(12'h008, 32'hF3F4_0000, "R8 clock select");
    rd(12'h070, S1, "R8 strap1 from pin");
    rd(12'h0D0, S2, "R8 strap2 from pin");
    rd(12'h07C, REV, "R8 revision from pin");
    rd(12'h000, 32'h0, "R8 key word from pin");
    rd(12'h104, 32'h8000_0000, "R8 open region init");
    rd(12'h150, 32'h1234_ABCD, "R8 chip id");

    // R2 locked region
    wr(12'h008, 32'h1234_5678, 1'b1, "R2 locked write refused");
    rd(12'h008, 32'hF3F4_0000, "R2 locked word unchanged");
    wr(12'h070, 32'hFFFF_FFFF, 1'b1, "R2 locked strap write refused");
    rd(12'h070, S1, "R2 strap unchanged while locked");
    wr(12'h104, 32'hCAFE_0104, 1'b0, "R2 open region writable");
    rd(12'h104, 32'hCAFE_0104, "R2 open region readback");

    // R1 key
    wr(12'h000, 32'h0000_0005, 1'b0, "R1 wrong key accepted as write");
    rd(12'h000, 32'h0, "R1 wrong key stores 0");
    wr(12'h000, KEY, 1'b0, "R1 right key");
    rd(12'h000, 32'h1, "R1 right key stores 1");
    wr(12'h008, 32'h1234_5678, 1'b0, "R1 unlocked write");
    rd(12'h008, 32'h1234_5678, "R1 unlocked readback");

    // R3 / R4 strap set and clear
    wr(12'h070, 32'h0000_0100, 1'b0, "R3 strap or");
    rd(12'h070, S1 | 32'h0000_0100, "R3 strap or result");
    wr(12'h07C, 32'h00F0_0000, 1'b0, "R4 strap clear via revision");
    rd(12'h070, 32'h0000_0101, "R4 strap bits cleared");
    rd(12'h07C, REV, "R4 revision unchanged");

    // R6 read-only words
    wr(12'h014, 32'hAAAA_AAAA, 1'b1, "R6 freq result write");
    rd(12'h014, 32'h0, "R6 freq result unchanged");
    wr(12'h05C, 32'h1111_1111, 1'b1, "R6 scratch write");
    rd(12'h05C, 32'h0, "R6 scratch unchanged");
    wr(12'h0E4, 32'h2222_2222, 1'b1, "R6 free counter write");
    rd(12'h0E4, 32'h0000_00FF, "R6 free counter unchanged");
    wr(12'h154, 32'h3333_3333, 1'b1, "R6 chip id write");
    rd(12'h154, 32'h8888_4444, "R6 chip id unchanged");

    // R5 random data, independent of enable word
    wr(12'h074, 32'h0, 1'b0, "R5 clear enable word");
    wr(12'h078, 32'h4444_4444, 1'b1, "R6 random data write");
    s = SEED;
    for (int i = 0; i < 4; i++) begin
      rd(12'h078, s, "R5 random sequence");
      s = lfsr_next(s);
    end
    wr(12'h074, 32'hFFFF_FFFF, 1'b0, "R5 set enable word");
    rd(12'h078, s, "R5 random continues");

    // R7 out of range
    rd(12'h1A8, 32'h0, "R7 out of range read");
    wr(12'h1A8, 32'h5555_5555, 1'b1, "R7 out of range write");
    rd(12'hFFC, 32'h0, "R7 top address read");
    wr(12'h1A4, 32'h7777_0001, 1'b0, "R7 last word writable");
    rd(12'h1A4, 32'h7777_0001, "R7 last word readback");

    // R9 misaligned
    wr(12'h00A, 32'hDEAD_BEEF, 1'b1, "R9 misaligned write");
    rd(12'h008, 32'h1234_5678, "R9 target word unchanged");
    rd(12'h005, 32'h0, "R9 misaligned read zero");

    // R1 relock, R2 refused again
    wr(12'h000, KEY ^ 32'h1, 1'b0, "R1 relock");
    rd(12'h000, 32'h0, "R1 relocked value");
    wr(12'h008, 32'h0, 1'b1, "R2 refused after relock");
    rd(12'h008, 32'h1234_5678, "R2 unchanged after relock");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule